// File: doc/BRIEF.md
# APB Burst Command Requester

This block turns commands into APB transfers. Commands arrive on a command port with a valid/ready handshake. Each command is an idle request, a single write, a single read or a burst. The block drives a 32-bit APB requester interface that has no wait-state input and no error input, so every transfer completes in exactly two clocks: a setup cycle followed by an access cycle. After a single transfer the engine inserts the number of idle bus cycles carried by the command. When the bus is idle the select, enable and write-data pins are driven low. The address and direction pins keep their last values so that they do not toggle.

A burst command runs a parameterized number of beats back to back, with no idle cycle between beats. Beat i goes to the command address plus 4·i and, for writes, takes word i of a data buffer that is latched when the command is accepted. A burst always finishes with exactly one idle cycle. Each read beat returns its data on a response port. Every command, whatever its kind, signals its completion with a one-cycle done pulse in the cycle where the command port becomes ready again.

Top module: `apb_burst_requester`

## Requirements
- R1: A single WRITE or READ accepted at clock edge E0 is driven as a setup cycle (psel=1, penable=0) after E0. It is followed by an access cycle (psel=1, penable=1) after E0+1. paddr, pwrite and pwdata stay identical in both cycles. pwdata equals the write data for a write and 0 for a read.
- R2: In every cycle that is not a setup or access cycle, psel, penable and pwdata are 0. paddr and pwrite keep the values of the most recent transfer, or 0 if there has been no transfer since reset.
- R3: cmd_kind encodes 00 as IDLE, 01 as WRITE, 10 as READ and 11 as IDLE. After a single WRITE or READ with idle count N (0 to 2^IDLE_W-1), exactly N idle cycles follow the access cycle before the command completes.
- R4: An IDLE command produces exactly one idle cycle and no transfer. cmd_idle and cmd_burst have no effect on it.
- R5: A WRITE or READ with cmd_burst=1 issues BURST_LEN transfers with no idle cycle between them. Beat i uses address cmd_addr+4·i, computed modulo 2^32. For writes, beat i uses write data cmd_bdata[32·i+31:32·i]. Exactly one idle cycle follows the last beat, and cmd_idle has no effect.
- R6: With BURST_LEN=0, a burst command issues no transfer and only the trailing idle cycle.
- R7: rsp_valid is high for exactly the cycle after each read access cycle. In that cycle rsp_data equals the prdata value present during the access cycle, and rsp_beat equals the beat index, which is 0 for a single read.
- R8: cmd_ready is high only when no command is in progress. It is low from the cycle after acceptance until the last cycle of the command. done is a one-cycle pulse in the first cycle in which cmd_ready is high again.
- R9: Driving rst_n low immediately sets paddr, pwrite, psel, penable, pwdata, done and rsp_valid to 0 and cmd_ready to 1, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The engine can accept a command |
| cmd_kind | input | 2 | Command kind: 00 idle, 01 write, 10 read, 11 idle |
| cmd_burst | input | 1 | Run the write or read as a burst |
| cmd_addr | input | 32 | Transfer address, or burst base address |
| cmd_wdata | input | 32 | Write data for a single write |
| cmd_idle | input | IDLE_W | Idle cycles after a single transfer |
| cmd_bdata | input | 32·max(BURST_LEN,1) | Burst write words, word i in bits 32·i+31:32·i |
| paddr | output | 32 | APB address |
| pwrite | output | 1 | APB direction, 1 for write |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| rsp_valid | output | 1 | Read data is valid |
| rsp_data | output | 32 | Read data |
| rsp_beat | output | BEAT_W | Beat index of the read data |
| done | output | 1 | Command completed |

## Verification
Take acceptance at clock edge E0 and let a command have B transfer beats and G idle cycles. Setup for beat b is then visible after edge E0+2b, access after E0+2b+1 and the read response after E0+2b+2. done and cmd_ready appear after edge E0+2B+G. The bench derives B and G from the command and the parameters. It samples every cycle at the falling edge, from the first cycle after acceptance up to the done cycle, and compares every bus pin, the response port and the handshake against those arithmetic positions. Read data comes from a bench slave whose prdata is a fixed function of paddr, so the expected response is computed from the beat address. Reset is also asserted in the middle of a setup cycle and checked before the next edge.

// File: rtl/apbq_pkg.sv
package apbq_pkg;

    localparam int AW         = 32;
    localparam int DW         = 32;
    localparam int WORD_SHIFT = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_READY,
        PH_SETUP,
        PH_ACCESS,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          write;
    } beat_t;

    function automatic logic is_xfer(input op_e op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    function automatic logic on_bus(input phase_e ph);
        return (ph == PH_SETUP) || (ph == PH_ACCESS);
    endfunction

endpackage

// File: rtl/apbq_seq.sv
module apbq_seq
    import apbq_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int IDLE_W    = 4,
    parameter int BUF_N     = 4,
    parameter int BEAT_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_kind,
    input  logic                cmd_burst,
    input  logic [AW-1:0]       cmd_addr,
    input  logic [DW-1:0]       cmd_wdata,
    input  logic [IDLE_W-1:0]   cmd_idle,
    input  logic [BUF_N*DW-1:0] cmd_bdata,
    output phase_e              phase,
    output phase_e              nxt_phase,
    output beat_t               nxt_beat,
    output logic [BEAT_W-1:0]   beat_idx,
    output logic                cur_write
);

    localparam int                WORDS = 2 ** BEAT_W;
    localparam logic [BEAT_W-1:0] LAST  = BEAT_W'(BUF_N - 1);

    op_e                op;
    phase_e             ph_q, ph_d;
    logic [BEAT_W-1:0]  beat_q, beat_d;
    logic [IDLE_W-1:0]  gap_q, gap_d, idle_q;
    logic [AW-1:0]      base_q, base_sel;
    logic [DW-1:0]      wsing_q, wsing_sel, wword;
    logic               write_q, burst_q, wr_sel, burst_sel, accept;
    logic [DW-1:0]      words_in [WORDS];
    logic [DW-1:0]      words_q  [WORDS];

    assign op     = op_e'(cmd_kind);
    assign accept = cmd_valid && (ph_q == PH_READY);

    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_word
            if (i < BUF_N) begin : g_used
                assign words_in[i] = cmd_bdata[DW*i +: DW];
            end else begin : g_pad
                assign words_in[i] = '0;
            end
        end
    endgenerate

    always_comb begin
        ph_d   = ph_q;
        beat_d = beat_q;
        gap_d  = gap_q;
        case (ph_q)
            PH_READY: begin
                if (cmd_valid) begin
                    beat_d = '0;
                    if (!is_xfer(op) || (cmd_burst && (BURST_LEN == 0))) begin
                        ph_d  = PH_GAP;
                        gap_d = IDLE_W'(1);
                    end else begin
                        ph_d = PH_SETUP;
                    end
                end
            end
            PH_SETUP: ph_d = PH_ACCESS;
            PH_ACCESS: begin
                if (burst_q && (beat_q != LAST)) begin
                    ph_d   = PH_SETUP;
                    beat_d = beat_q + 1'b1;
                end else if (burst_q) begin
                    ph_d  = PH_GAP;
                    gap_d = IDLE_W'(1);
                end else if (idle_q == '0) begin
                    ph_d = PH_READY;
                end else begin
                    ph_d  = PH_GAP;
                    gap_d = idle_q;
                end
            end
            default: begin
                if (gap_q <= IDLE_W'(1)) ph_d = PH_READY;
                else                     gap_d = gap_q - 1'b1;
            end
        endcase
    end

    always_comb begin
        base_sel  = (ph_q == PH_READY) ? cmd_addr : base_q;
        wsing_sel = (ph_q == PH_READY) ? cmd_wdata : wsing_q;
        wr_sel    = (ph_q == PH_READY) ? (op == OP_WRITE) : write_q;
        burst_sel = (ph_q == PH_READY) ? cmd_burst : burst_q;
        wword     = (ph_q == PH_READY) ? words_in[beat_d] : words_q[beat_d];
        nxt_beat.addr  = base_sel + (AW'(beat_d) << WORD_SHIFT);
        nxt_beat.write = wr_sel;
        nxt_beat.wdata = !wr_sel ? '0 : (burst_sel ? wword : wsing_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= PH_READY;
            beat_q  <= '0;
            gap_q   <= '0;
            idle_q  <= '0;
            base_q  <= '0;
            wsing_q <= '0;
            write_q <= 1'b0;
            burst_q <= 1'b0;
            for (int i = 0; i < WORDS; i++) words_q[i] <= '0;
        end else begin
            ph_q   <= ph_d;
            beat_q <= beat_d;
            gap_q  <= gap_d;
            if (accept) begin
                idle_q  <= cmd_idle;
                base_q  <= cmd_addr;
                wsing_q <= cmd_wdata;
                write_q <= (op == OP_WRITE);
                burst_q <= cmd_burst;
                for (int i = 0; i < WORDS; i++) words_q[i] <= words_in[i];
            end
        end
    end

    assign cmd_ready = (ph_q == PH_READY);
    assign phase     = ph_q;
    assign nxt_phase = ph_d;
    assign beat_idx  = beat_q;
    assign cur_write = write_q;

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready); // R8
    AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        on_bus(ph_q) |-> (beat_q <= LAST)); // R5

endmodule

// File: rtl/apbq_drv.sv
module apbq_drv
    import apbq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        nxt_phase,
    input  beat_t         nxt_beat,
    output logic [AW-1:0] paddr,
    output logic          pwrite,
    output logic          psel,
    output logic          penable,
    output logic [DW-1:0] pwdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr   <= '0;
            pwrite  <= 1'b0;
            psel    <= 1'b0;
            penable <= 1'b0;
            pwdata  <= '0;
        end else begin
            psel    <= on_bus(nxt_phase);
            penable <= (nxt_phase == PH_ACCESS);
            if (nxt_phase == PH_SETUP) begin
                paddr  <= nxt_beat.addr;
                pwrite <= nxt_beat.write;
                pwdata <= nxt_beat.wdata;
            end else if (nxt_phase != PH_ACCESS) begin
                pwdata <= '0;
            end
        end
    end

    AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> psel && penable); // R1
    AST_ENABLE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel); // R1
    AST_ACCESS_KEEPS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> $stable(paddr) && $stable(pwrite) && $stable(pwdata)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |-> !penable && (pwdata == '0)); // R2
    AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |=> psel || ($stable(paddr) && $stable(pwrite))); // R2

endmodule

// File: rtl/apbq_rsp.sv
module apbq_rsp
    import apbq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  phase_e            nxt_phase,
    input  logic              cur_write,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic [DW-1:0]     prdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic [BEAT_W-1:0] rsp_beat,
    output logic              done
);

    logic rd_access;
    assign rd_access = (phase == PH_ACCESS) && !cur_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_beat  <= '0;
            done      <= 1'b0;
        end else begin
            rsp_valid <= rd_access;
            done      <= (phase != PH_READY) && (nxt_phase == PH_READY);
            if (rd_access) begin
                rsp_data <= prdata;
                rsp_beat <= beat_idx;
            end
        end
    end

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_READY)); // R8
    AST_RSP_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (phase != PH_ACCESS)); // R7

endmodule

// File: rtl/apb_burst_requester.sv
module apb_burst_requester
    import apbq_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int IDLE_W    = 4,
    localparam int BUF_N    = (BURST_LEN < 1) ? 1 : BURST_LEN,
    localparam int BEAT_W   = (BUF_N > 1) ? $clog2(BUF_N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_kind,
    input  logic                cmd_burst,
    input  logic [31:0]         cmd_addr,
    input  logic [31:0]         cmd_wdata,
    input  logic [IDLE_W-1:0]   cmd_idle,
    input  logic [BUF_N*32-1:0] cmd_bdata,
    output logic [31:0]         paddr,
    output logic                pwrite,
    output logic                psel,
    output logic                penable,
    output logic [31:0]         pwdata,
    input  logic [31:0]         prdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_data,
    output logic [BEAT_W-1:0]   rsp_beat,
    output logic                done
);

    phase_e            phase, nxt_phase;
    beat_t             nxt_beat;
    logic [BEAT_W-1:0] beat_idx;
    logic              cur_write;

    apbq_seq #(
        .BURST_LEN(BURST_LEN), .IDLE_W(IDLE_W), .BUF_N(BUF_N), .BEAT_W(BEAT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_burst(cmd_burst), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_idle(cmd_idle), .cmd_bdata(cmd_bdata),
        .phase(phase), .nxt_phase(nxt_phase), .nxt_beat(nxt_beat),
        .beat_idx(beat_idx), .cur_write(cur_write)
    );

    apbq_drv u_drv (
        .clk(clk), .rst_n(rst_n), .nxt_phase(nxt_phase), .nxt_beat(nxt_beat),
        .paddr(paddr), .pwrite(pwrite), .psel(psel), .penable(penable),
        .pwdata(pwdata)
    );

    apbq_rsp #(.BEAT_W(BEAT_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .phase(phase), .nxt_phase(nxt_phase),
        .cur_write(cur_write), .beat_idx(beat_idx), .prdata(prdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_beat(rsp_beat),
        .done(done)
    );

    AST_IDLE_BUS_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !psel); // R2

endmodule

// File: tb/sim_apb_burst_requester.sv
module sim_apb_burst_requester;

    localparam int CLK_NS = 10;
    localparam int LEN    = 4;
    localparam int IW     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic          cmd_valid = 1'b0, bsel = 1'b0, cmd_burst = 1'b0;
    logic [1:0]    cmd_kind = 2'b00;
    logic [31:0]   cmd_addr = '0, cmd_wdata = '0;
    logic [IW-1:0] cmd_idle = '0;
    logic [127:0]  cmd_bdata = '0;
    logic          v0, v1;
    assign v0 = cmd_valid && !bsel;
    assign v1 = cmd_valid && bsel;

    function automatic logic [31:0] slave_rd(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h0101};
    endfunction

    logic        rdy0, pw0, ps0, pe0, rv0, dn0;
    logic [31:0] pa0, pd0, rd0;
    logic [1:0]  bt0;
    logic        rdy1, pw1, ps1, pe1, rv1, dn1;
    logic [31:0] pa1, pd1, rd1;
    logic [0:0]  bt1;

    apb_burst_requester #(.BURST_LEN(LEN), .IDLE_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(v0), .cmd_ready(rdy0),
        .cmd_kind(cmd_kind), .cmd_burst(cmd_burst), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_idle(cmd_idle), .cmd_bdata(cmd_bdata),
        .paddr(pa0), .pwrite(pw0), .psel(ps0), .penable(pe0), .pwdata(pd0),
        .prdata(slave_rd(pa0)), .rsp_valid(rv0), .rsp_data(rd0),
        .rsp_beat(bt0), .done(dn0)
    );

    apb_burst_requester #(.BURST_LEN(0), .IDLE_W(IW)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(v1), .cmd_ready(rdy1),
        .cmd_kind(cmd_kind), .cmd_burst(cmd_burst), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_idle(cmd_idle), .cmd_bdata(cmd_bdata[31:0]),
        .paddr(pa1), .pwrite(pw1), .psel(ps1), .penable(pe1), .pwdata(pd1),
        .prdata(slave_rd(pa1)), .rsp_valid(rv1), .rsp_data(rd1),
        .rsp_beat(bt1), .done(dn1)
    );

    logic        o_rdy, o_pw, o_ps, o_pe, o_rv, o_dn;
    logic [31:0] o_pa, o_pd, o_rd, o_bt;
    always_comb begin
        if (bsel) begin
            {o_rdy, o_pw, o_ps, o_pe, o_rv, o_dn} = {rdy1, pw1, ps1, pe1, rv1, dn1};
            {o_pa, o_pd, o_rd} = {pa1, pd1, rd1};
            o_bt = 32'(bt1);
        end else begin
            {o_rdy, o_pw, o_ps, o_pe, o_rv, o_dn} = {rdy0, pw0, ps0, pe0, rv0, dn0};
            {o_pa, o_pd, o_rd} = {pa0, pd0, rd0};
            o_bt = 32'(bt0);
        end
    end

    int          n_chk = 0, n_fail = 0;
    logic [31:0] last_a [2] = '{32'h0, 32'h0};
    logic        last_w [2] = '{1'b0, 1'b0};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run(input bit sel, input logic [1:0] op, input bit burst,
                       input logic [31:0] addr, input logic [31:0] wdata,
                       input logic [IW-1:0] idle, input logic [127:0] bdata);
        int b_n, g_n, t_n, bi, si;
        bit w, xfer;
        string md;
        logic [31:0] ea, ed;
        xfer = (op == 2'b01) || (op == 2'b10);
        w    = (op == 2'b01);
        si   = sel ? 1 : 0;
        if (!xfer)      begin b_n = 0; g_n = 1; md = "R4"; end
        else if (burst) begin b_n = sel ? 0 : LEN; g_n = 1; md = sel ? "R6" : "R5"; end
        else            begin b_n = 1; g_n = int'(idle); md = "R3"; end
        t_n = 2*b_n + g_n + 1;
        bsel = sel;
        chk(o_rdy == 1'b1, "R8 ready before command", 32'(o_rdy), 32'h1);
        cmd_kind = op; cmd_burst = burst; cmd_addr = addr; cmd_wdata = wdata;
        cmd_idle = idle; cmd_bdata = bdata; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_kind = 2'b11; cmd_addr = ~addr; cmd_wdata = ~wdata; cmd_bdata = ~bdata;
        for (int c = 1; c <= t_n; c++) begin
            if (c > 1) @(negedge clk);
            if (b_n > 0 && c == 2*b_n + 1) begin
                last_a[si] = addr + 32'(4*(b_n-1));
                last_w[si] = w;
            end
            if (c <= 2*b_n) begin
                bi = (c - 1) / 2;
                ea = addr + 32'(4*bi);
                ed = !w ? 32'h0 : (burst ? bdata[32*bi +: 32] : wdata);
                chk(o_ps == 1'b1, burst ? "R5 psel in beat" : "R1 psel in transfer", 32'(o_ps), 32'h1);
                chk(o_pe == ((c % 2) == 0), "R1 penable phase", 32'(o_pe), 32'((c % 2) == 0));
                chk(o_pa == ea, burst ? "R5 beat address" : "R1 address", o_pa, ea);
                chk(o_pw == w, "R1 direction", 32'(o_pw), 32'(w));
                chk(o_pd == ed, burst ? "R5 beat write data" : "R1 write data", o_pd, ed);
                chk(o_rdy == 1'b0, "R8 ready low in transfer", 32'(o_rdy), 32'h0);
            end else begin
                chk(o_ps == 1'b0 && o_pe == 1'b0, "R2 select/enable low in idle",
                    32'({o_ps, o_pe}), 32'h0);
                chk(o_pd == 32'h0, "R2 pwdata zero in idle", o_pd, 32'h0);
                chk(o_pa == last_a[si], "R2 paddr held in idle", o_pa, last_a[si]);
                chk(o_pw == last_w[si], "R2 pwrite held in idle", 32'(o_pw), 32'(last_w[si]));
                chk(o_rdy == (c == t_n), {md, " ready after idle gap"}, 32'(o_rdy), 32'(c == t_n));
            end
            chk(o_dn == (c == t_n), {md, " R8 done pulse"}, 32'(o_dn), 32'(c == t_n));
            if (!w && xfer && b_n > 0 && (c % 2) == 1 && c >= 3 && c <= 2*b_n + 1) begin
                bi = (c - 3) / 2;
                ea = slave_rd(addr + 32'(4*bi));
                chk(o_rv == 1'b1, "R7 rsp_valid", 32'(o_rv), 32'h1);
                chk(o_rd == ea, "R7 read data", o_rd, ea);
                chk(o_bt == 32'(bi), "R7 beat index", o_bt, 32'(bi));
            end else begin
                chk(o_rv == 1'b0, "R7 no rsp_valid", 32'(o_rv), 32'h0);
            end
        end
    endtask

    function automatic logic [127:0] mk_buf(input int k);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) r[32*i +: 32] = 32'h1357_0000 + 32'(k*32'h0011_0101) + 32'(i*32'h0203);
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(ps0 == 0 && pe0 == 0 && pw0 == 0, "R9 control pins in reset", 32'({ps0, pe0, pw0}), 32'h0);
        chk(pa0 == 0 && pd0 == 0, "R9 addr/data in reset", pa0 | pd0, 32'h0);
        chk(rdy0 == 1 && dn0 == 0 && rv0 == 0, "R9 handshake in reset", 32'({rdy0, dn0, rv0}), 32'h4);
        rst_n = 1'b1;
        @(negedge clk);

        for (int op = 1; op <= 2; op++)
            for (int idl = 0; idl < 16; idl++)
                run(1'b0, 2'(op), 1'b0, 32'hA000_0000 + 32'((idl+1) * 32'h1000) + 32'(op * 32'h30),
                    32'hC0DE_0000 ^ 32'(idl * 32'h0101_0101) ^ 32'(op), IW'(idl), '0);

        run(1'b0, 2'b00, 1'b1, 32'h1111_1110, 32'hFFFF_FFFF, 4'd9, mk_buf(7));   // R4
        run(1'b0, 2'b11, 1'b0, 32'h2222_2220, 32'h1234_5678, 4'd5, '0);          // R4
        for (int k = 0; k < 3; k++) begin
            run(1'b0, 2'b01, 1'b1, 32'h8000_0000 + 32'(k * 32'h100), 32'hDEAD_BEEF, 4'd9, mk_buf(k));
            run(1'b0, 2'b10, 1'b1, 32'h8000_0000 + 32'(k * 32'h100), 32'h0, 4'd3, '0);
        end
        run(1'b0, 2'b01, 1'b1, 32'hFFFF_FFF8, 32'h0, 4'd0, mk_buf(9));          // R5 wrap
        run(1'b0, 2'b10, 1'b1, 32'hFFFF_FFF8, 32'h0, 4'd15, '0);                // R5 wrap
        run(1'b0, 2'b00, 1'b0, 32'h0, 32'h0, 4'd0, '0);                         // R2 hold after wrap

        run(1'b1, 2'b01, 1'b0, 32'h0000_4444, 32'h0BAD_F00D, 4'd2, '0);
        run(1'b1, 2'b01, 1'b1, 32'h0000_5550, 32'h0, 4'd4, mk_buf(3));          // R6
        run(1'b1, 2'b10, 1'b1, 32'h0000_6660, 32'h0, 4'd1, '0);                 // R6
        run(1'b1, 2'b10, 1'b0, 32'h0000_7770, 32'h0, 4'd0, '0);

        // R9: asynchronous reset during a setup cycle
        bsel = 1'b0;
        cmd_kind = 2'b01; cmd_burst = 1'b0; cmd_addr = 32'h3C3C_3C3C;
        cmd_wdata = 32'h9999_AAAA; cmd_idle = 4'd1; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(ps0 == 1'b1, "R9 setup before reset", 32'(ps0), 32'h1);
        #1 rst_n = 1'b0;
        #1;
        chk(ps0 == 0 && pe0 == 0 && pw0 == 0, "R9 async control clear", 32'({ps0, pe0, pw0}), 32'h0);
        chk(pa0 == 0 && pd0 == 0, "R9 async addr/data clear", pa0 | pd0, 32'h0);
        chk(rdy0 == 1 && dn0 == 0 && rv0 == 0, "R9 async handshake", 32'({rdy0, dn0, rv0}), 32'h4);
        @(negedge clk);
        rst_n = 1'b1;
        last_a[0] = 32'h0; last_w[0] = 1'b0;
        @(negedge clk);
        run(1'b0, 2'b10, 1'b0, 32'h0000_0040, 32'h0, 4'd1, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule